// File: doc/BRIEF.md
# Four-Channel PWM Generator with Boundary-Committed Settings

This block produces four independent pulse-width-modulated outputs. Each channel has a tick divider, a period length counted in ticks and a high-time count. Software programs these through a small register bus, which has an address, write data, a write strobe and a combinational read-data return. Each channel owns a 32-byte window. The channel number sits in address bits [6:5], and the low five bits select the register inside the window.

Writes to the divider, period and high-time registers land in holding registers and leave the running waveform untouched. A write to the high-time register arms a commit. When the running period ends, the channel copies all three held values into its working set together, so no period ever mixes old and new settings. Enabling an idle channel loads the held values at once and starts counting from zero. Disabling a channel forces its output low on the next clock, even in the middle of a period.

The bus is a register interface with no data stream, so it has no valid/ready handshake. A write takes effect on the clock edge where `bus_we` is high. A read returns data in the same cycle as the address.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset, every register of every channel reads 0 and all `pwm_o` bits are low.
- R2: Reads return the last written value masked to the field width, and unused bits read 0. The window offsets are: divider at 0x00 (bits [7:0]), period at 0x04 (bits [7:0]), high time at 0x08 (bits [15:0]) and enable at 0x18 (bit 0).
- R3: A read of any other offset, or of any address with bit 7 set, returns 0. A write there changes no register.
- R4: With divider P, period M and high time D, the output repeats every (P+1)·M clocks. Each period starts high, and the output stays high for the first (P+1)·D clocks of it.
- R5: If D >= M, the output is high for the whole period. If D = 0, the output stays low.
- R6: Writes to the divider or the period alone never change the waveform.
- R7: A high-time write arms a commit. All three held values become active together at the end of the running period, never in the middle of it.
- R8: Writing enable=1 to a disabled channel loads the held values at once and restarts counting from zero. With D > 0, the output is high in the cycle right after the write. Writing enable=1 to a running channel does not restart it.
- R9: Writing enable=0 drives that output low in the next cycle and resets the channel's counters.
- R10: Channel n occupies addresses 32·n to 32·n+31, and channels never affect each other.
- R11: A period value of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
Directed cases cover the following patterns:
- Held period writes without a commit. These show that the period setting is really held back.
- A high-time write in the middle of a period. This separates a commit at the period boundary from an immediate one.
- High times of zero, at the period and far beyond it. These cover the always-low and always-high ends.
- A period of zero.
- Disabling and then re-enabling a channel in the middle of a period. This shows that the channel restarts from zero.

Random register traffic with small dividers drives all four channels at once. Each output is compared every cycle against a reference model built on period counts, which exposes any crosstalk between channels or any off-by-one error in the period.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  // Offsets inside one channel window (software visible)
  localparam logic [4:0] OFS_DIV    = 5'h00;
  localparam logic [4:0] OFS_PERIOD = 5'h04;
  localparam logic [4:0] OFS_HIGH   = 5'h08;
  localparam logic [4:0] OFS_RUN    = 5'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIV,
    SEL_PERIOD,
    SEL_HIGH,
    SEL_RUN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [4:0] ofs);
    case (ofs)
      OFS_DIV:    return SEL_DIV;
      OFS_PERIOD: return SEL_PERIOD;
      OFS_HIGH:   return SEL_HIGH;
      OFS_RUN:    return SEL_RUN;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pwmc_divider.sv
module pwmc_divider #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: the divider never runs past its limit while the channel runs
  a_r4_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_div,
  input  logic              wr_period,
  input  logic              wr_high,
  input  logic              wr_run,
  input  logic [DUTY_W-1:0] wdata,
  output logic [PRE_W-1:0]  div_q,
  output logic [MOD_W-1:0]  period_q,
  output logic [DUTY_W-1:0] high_q,
  output logic              run_q,
  output logic              pwm_o
);
  logic [PRE_W-1:0]  div_act;
  logic [MOD_W-1:0]  period_act;
  logic [DUTY_W-1:0] high_act;
  logic              armed_q;
  logic [MOD_W-1:0]  step_q;
  logic              tick;
  logic              stop_now;
  logic              start_now;
  logic              last_step;
  logic              period_end;

  assign stop_now   = wr_run && !wdata[0];
  assign start_now  = wr_run && wdata[0] && !run_q;
  assign last_step  = ({1'b0, step_q} + 1'b1) >= {1'b0, period_act};
  assign period_end = tick && last_step;

  pwmc_divider #(.PRE_W(PRE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q && !stop_now),
    .limit (div_act),
    .tick  (tick)
  );

  // Software-visible holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      period_q <= '0;
      high_q   <= '0;
      run_q    <= 1'b0;
    end else begin
      if (wr_div)    div_q    <= wdata[PRE_W-1:0];
      if (wr_period) period_q <= wdata[MOD_W-1:0];
      if (wr_high)   high_q   <= wdata;
      if (wr_run)    run_q    <= wdata[0];
    end
  end

  // Working set and commit flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act    <= '0;
      period_act <= '0;
      high_act   <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (start_now || (period_end && armed_q)) begin
        div_act    <= div_q;
        period_act <= period_q;
        high_act   <= high_q;
      end
      if (wr_high)                          armed_q <= 1'b1;
      else if (start_now)                   armed_q <= 1'b0;
      else if (period_end && armed_q)       armed_q <= 1'b0;
    end
  end

  // Step counter within the period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 step_q <= '0;
    else if (!run_q || stop_now) step_q <= '0;
    else if (tick)              step_q <= last_step ? '0 : step_q + 1'b1;
  end

  assign pwm_o = run_q && ({{(DUTY_W-MOD_W){1'b0}}, step_q} < high_act);

  // R9: disabling forces the output low on the following cycle
  a_r9_stop_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !pwm_o);
  // R8: enabling an idle channel with nonzero high time starts high
  a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_now && high_q != '0) |=> pwm_o);
  // R7: the working set only moves at a boundary or a fresh start
  a_r7_no_midperiod_change: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !period_end && !wr_run) |=> ($stable(high_act) && $stable(period_act) && $stable(div_act)));
  // R4: the step counter stays inside the period
  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && period_act != '0) |-> (step_q < period_act));
  // R9: an idle channel keeps its output low
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |-> (!pwm_o && step_q == '0));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl #(
  parameter int NCH       = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRE_W     = 8,
  parameter int MOD_W     = 8,
  parameter int DUTY_W    = 16,
  parameter int WIN_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  import pwmc_pkg::*;

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0]   ch_idx;
  logic [ADDR_W-1:0] addr_hi;
  logic              ch_ok;
  reg_sel_e          sel;
  logic              unused_wdata_hi;

  assign ch_idx          = bus_addr[WIN_SHIFT +: CH_W];
  assign addr_hi         = bus_addr >> (WIN_SHIFT + CH_W);
  assign ch_ok           = (addr_hi == '0) && (int'(ch_idx) < NCH);
  assign sel             = decode_ofs(bus_addr[WIN_SHIFT-1:0]);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DUTY_W];

  logic [PRE_W-1:0]  rd_div    [NCH];
  logic [MOD_W-1:0]  rd_period [NCH];
  logic [DUTY_W-1:0] rd_high   [NCH];
  logic              rd_run    [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = bus_we && ch_ok && (ch_idx == CH_W'(g));

    pwmc_channel #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_div    (hit && sel == SEL_DIV),
      .wr_period (hit && sel == SEL_PERIOD),
      .wr_high   (hit && sel == SEL_HIGH),
      .wr_run    (hit && sel == SEL_RUN),
      .wdata     (bus_wdata[DUTY_W-1:0]),
      .div_q     (rd_div[g]),
      .period_q  (rd_period[g]),
      .high_q    (rd_high[g]),
      .run_q     (rd_run[g]),
      .pwm_o     (pwm_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (ch_ok) begin
      case (sel)
        SEL_DIV:    bus_rdata = DATA_W'(rd_div[ch_idx]);
        SEL_PERIOD: bus_rdata = DATA_W'(rd_period[ch_idx]);
        SEL_HIGH:   bus_rdata = DATA_W'(rd_high[ch_idx]);
        SEL_RUN:    bus_rdata = DATA_W'(rd_run[ch_idx]);
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R3: addresses outside every window always read zero
  a_r3_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_ok) |-> (bus_rdata == '0));
endmodule

// File: tb/pwm_shadow_ctrl_tb.sv
module pwm_shadow_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  pwm_shadow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model, built on position within the period
  logic [7:0]  m_div [4], m_per [4], a_div [4], a_per [4];
  logic [15:0] m_high [4], a_high [4];
  bit          m_run [4], m_arm [4];
  int          m_pos [4];

  function automatic int per_len(input int c);
    int mx;
    mx = (a_per[c] == 0) ? 1 : int'(a_per[c]);
    return (int'(a_div[c]) + 1) * mx;
  endfunction

  function automatic bit exp_pwm(input int c);
    return m_run[c] && ((m_pos[c] / (int'(a_div[c]) + 1)) < int'(a_high[c]));
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int c;
    c = int'(a[6:5]);
    if (a[7]) return 32'h0;
    case (a[4:0])
      5'h00:   return {24'h0, m_div[c]};
      5'h04:   return {24'h0, m_per[c]};
      5'h08:   return {16'h0, m_high[c]};
      5'h18:   return {31'h0, m_run[c]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_div[c] = 0; m_per[c] = 0; m_high[c] = 0; a_div[c] = 0; a_per[c] = 0;
        a_high[c] = 0; m_run[c] = 0; m_arm[c] = 0; m_pos[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (m_run[c]) begin
          m_pos[c]++;
          if (m_pos[c] >= per_len(c)) begin
            m_pos[c] = 0;
            if (m_arm[c]) begin
              a_div[c] = m_div[c]; a_per[c] = m_per[c]; a_high[c] = m_high[c];
              m_arm[c] = 0;
            end
          end
        end
      end
      if (bus_we && !bus_addr[7]) begin
        int c;
        c = int'(bus_addr[6:5]);
        case (bus_addr[4:0])
          5'h00: m_div[c] = bus_wdata[7:0];
          5'h04: m_per[c] = bus_wdata[7:0];
          5'h08: begin m_high[c] = bus_wdata[15:0]; m_arm[c] = 1; end
          5'h18: begin
            if (bus_wdata[0] && !m_run[c]) begin
              m_run[c] = 1; m_pos[c] = 0; m_arm[c] = 0;
              a_div[c] = m_div[c]; a_per[c] = m_per[c]; a_high[c] = m_high[c];
            end else if (!bus_wdata[0]) begin
              m_run[c] = 0; m_pos[c] = 0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle output comparison, away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        vectors++;
        if (pwm_o[c] !== exp_pwm(c)) begin
          fails++;
          $display("FAIL %s pwm_o[%0d] actual=%0b expected=%0b at %0t",
                   cur_req, c, pwm_o[c], exp_pwm(c), $time);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    e = exp_read(a);
    vectors++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic pin_chk(input int c, input bit e, input string tag);
    vectors++;
    if (pwm_o[c] !== e) begin
      fails++;
      $display("FAIL %s pwm_o[%0d] actual=%0b expected=%0b", tag, c, pwm_o[c], e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    for (int c = 0; c < 4; c++) begin
      rd_chk(8'(c * 32 + 0), "R1"); rd_chk(8'(c * 32 + 4), "R1");
      rd_chk(8'(c * 32 + 8), "R1"); rd_chk(8'(c * 32 + 24), "R1");
      pin_chk(c, 1'b0, "R1");
    end

    // R2: field masking on readback
    cur_req = "R2";
    wr(8'h20, 32'hFFFF_FF03); rd_chk(8'h20, "R2");
    wr(8'h24, 32'h0000_01FF); rd_chk(8'h24, "R2");
    wr(8'h28, 32'h000A_BCDE); rd_chk(8'h28, "R2");
    wr(8'h38, 32'hFFFF_FFFE); rd_chk(8'h38, "R2");

    // R3: undefined offsets and out-of-range addresses
    cur_req = "R3";
    wr(8'h2C, 32'hDEAD_BEEF); rd_chk(8'h2C, "R3");
    wr(8'h80, 32'h0000_00FF); rd_chk(8'h80, "R3");
    wr(8'hB8, 32'h1);         rd_chk(8'hB8, "R3");
    rd_chk(8'h20, "R3"); rd_chk(8'h28, "R3"); rd_chk(8'h00, "R3"); rd_chk(8'h18, "R3");
    pin_chk(1, 1'b0, "R3");

    // R10: window stride and isolation
    cur_req = "R10";
    wr(8'h40, 32'h5); rd_chk(8'h40, "R10"); rd_chk(8'h20, "R10"); rd_chk(8'h60, "R10");

    // R8: start from idle is immediate and high
    cur_req = "R8";
    wr(8'h00, 32'd1); wr(8'h04, 32'd6); wr(8'h08, 32'd2);
    wr(8'h18, 32'd1);
    pin_chk(0, 1'b1, "R8");
    idle(5);
    wr(8'h18, 32'd1);   // already running: no restart
    idle(10);

    // R4: steady waveform
    cur_req = "R4";
    idle(60);

    // R6: held period write only
    cur_req = "R6";
    wr(8'h04, 32'd3); wr(8'h00, 32'd0);
    idle(50);

    // R7: commit at boundary
    cur_req = "R7";
    idle(3);
    wr(8'h08, 32'd5);
    idle(40);

    // R5: high time beyond period, then zero
    cur_req = "R5";
    wr(8'h08, 32'hFFFF); idle(30);
    pin_chk(0, 1'b1, "R5");
    wr(8'h08, 32'd0); idle(30);
    pin_chk(0, 1'b0, "R5");

    // R11: period of zero
    cur_req = "R11";
    wr(8'h04, 32'd0); wr(8'h00, 32'd2); wr(8'h08, 32'd1); idle(30);
    pin_chk(0, 1'b1, "R11");

    // R9: immediate stop and fresh restart
    cur_req = "R9";
    wr(8'h04, 32'd7); wr(8'h08, 32'd3); idle(17);
    wr(8'h18, 32'd0);
    pin_chk(0, 1'b0, "R9");
    idle(4);
    wr(8'h18, 32'd1);
    pin_chk(0, 1'b1, "R9");
    idle(20);

    // Random traffic over all channels (R4, R7, R10)
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int op;
      a  = 8'(($urandom % 4) * 32);
      op = $urandom % 8;
      case (op)
        0: wr(a + 8'h00, $urandom % 4);
        1: wr(a + 8'h04, $urandom % 12);
        2, 3: wr(a + 8'h08, $urandom % 14);
        4: wr(a + 8'h18, $urandom % 2);
        5: wr(a + 8'(($urandom % 8) * 4), $urandom);
        6: rd_chk(8'($urandom), "R3");
        default: rd_chk(a + 8'(($urandom % 8) * 4), "R2");
      endcase
      idle($urandom % 20);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule